// File: doc/BRIEF.md
# Byte-Addressed Host to 16-bit Asynchronous SRAM Bridge

This block sits between a Wishbone-style classic host and an asynchronous static RAM that is 16 bits wide and holds 1M words. The host addresses bytes and marks the bytes it wants with two byte selects. The memory addresses 16-bit words and has one active-low enable for each byte lane. The bridge drops host address bit 0 to form the word address. It maps the byte selects onto the lane enables, so a single-byte write leaves the other half of the word unchanged.

Each accepted host request becomes one memory access. The bridge registers every memory pin. It drives chip select, write enable or output enable for a parameterised number of strobe cycles, then holds address and data for one recovery cycle with the strobes released. It then returns the acknowledge for one cycle with chip select high. The bidirectional data bus is split into an output, a drive enable and an input, and the pad ring joins them.

Top module: `sram16_bridge`

## Requirements
- R1: During an access, all 20 bits of `sram_addr` (the most significant included) equal `host_adr[20:1]` of the accepted request. They stay unchanged from the first strobe cycle through the recovery cycle.
- R2: While `sram_ce_n` is low, `sram_lb_n` is low exactly when `host_sel[0]` was set (data bits 7:0), and `sram_ub_n` is low exactly when `host_sel[1]` was set (bits 15:8). Both are high while `sram_ce_n` is high. The host places a single byte on the lane given by `host_adr[0]` (0 = lower, 1 = upper) and issues full-word accesses at even addresses.
- R3: A write with one lane selected changes only that byte of the addressed word. The other byte keeps its value. A write with both lanes selected replaces the whole word.
- R4: During a read, `sram_oe_n` is low for the strobe cycles, `sram_we_n` stays high and `sram_dq_drive` stays low. The word present on `sram_dq_in` in the last strobe cycle appears on `host_rdat` (selected lanes) while `host_ack` is high.
- R5: During a write, `sram_oe_n` stays high. `sram_dq_drive` is high exactly in the cycles where `sram_we_n` is low, and `sram_dq_out` then equals `host_wdat`.
- R6: After reset and between accesses, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_lb_n` and `sram_ub_n` are high, while `sram_dq_drive` and `host_ack` are low.
- R7: A request is accepted at the first clock edge with the bridge idle and `host_cyc` and `host_stb` both high. `sram_ce_n` is then low for WAIT_CYCLES strobe cycles plus one recovery cycle. In the recovery cycle `sram_we_n` and `sram_oe_n` are high while address and data are unchanged. `host_ack` is then high for exactly one cycle with `sram_ce_n` high.
- R8: No new access starts before the acknowledge of the previous one. A strobe held high through an access starts the next access only at the edge after the acknowledge cycle.
- R9: `host_stb` with `host_cyc` low starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cyc | input | 1 | Host bus cycle in progress |
| host_stb | input | 1 | Host transfer request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_adr | input | 21 | Host byte address |
| host_sel | input | 2 | Host byte selects, bit 0 = bits 7:0 |
| host_wdat | input | 16 | Host write data |
| host_rdat | output | 16 | Read data, valid with acknowledge |
| host_ack | output | 1 | One-cycle transfer acknowledge |
| sram_addr | output | 20 | Memory word address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower lane enable, active low |
| sram_ub_n | output | 1 | Upper lane enable, active low |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_drive | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 16 | Data from the memory |

## Verification
The hardest cases to reach from the ports are a wrong upper address bit and a lost neighbour byte. Neither shows up when a word is written and then read back at the same place. The stimulus writes two words whose host addresses differ only in the top bit, then overwrites single lanes of each. The bench memory decodes that top bit separately, so an undriven or misplaced bit shows up as aliasing when the words are read back. A run of back-to-back requests, with the strobe left high across the acknowledge, exercises the rule that the next access waits for the acknowledge.

// File: rtl/sram16_bridge_pkg.sv
// Package: shared types for the byte-to-word SRAM bridge.
// Assumes a 16-bit memory split into two 8-bit lanes.
package sram16_bridge_pkg;
    localparam int SBR_LANES  = 2;
    localparam int SBR_LANE_W = 8;
    localparam int SBR_DATA_W = SBR_LANES * SBR_LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2,
        ST_ACK     = 2'd3
    } sbr_state_e;

    typedef struct packed {
        logic                  we;
        logic [SBR_LANES-1:0]  lane_n;
        logic [SBR_DATA_W-1:0] wdat;
    } sbr_req_t;
endpackage

// File: rtl/sbr_addr_map.sv
// Module: sbr_addr_map
// Turns a host byte address into a memory word address by dropping bit 0,
// and turns host byte selects into active-low lane enables.
// Assumes byte selects already sit on the lanes the host data occupies.
module sbr_addr_map #(
    parameter int HOST_AW = 21,
    localparam int WORD_AW = HOST_AW - 1,
    parameter int LANES   = 2
) (
    input  logic [HOST_AW-1:1] byte_adr_hi,
    input  logic [LANES-1:0]   byte_sel,
    output logic [WORD_AW-1:0] word_adr,
    output logic [LANES-1:0]   lane_en_n
);
    // word address: host bit 1 lands on memory bit 0, and so on upward
    assign word_adr = byte_adr_hi;

    // one active-low enable per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en_n[g] = ~byte_sel[g];
    end
endmodule

// File: rtl/sbr_wait_timer.sv
// Module: sbr_wait_timer
// Counts the strobe cycles of one access. Load sets the count so that
// done rises after WAIT_CYCLES cycles. Assumes WAIT_CYCLES >= 1.
module sbr_wait_timer #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);

    logic [CW-1:0] cnt_q;

    // reload on a new access, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(WAIT_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sbr_seq.sv
// Module: sbr_seq
// Access sequencer: idle, strobe for the timer period, one recovery
// cycle, one acknowledge cycle. Accepts a request only when idle.
module sbr_seq
    import sram16_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       timer_done,
    output sbr_state_e state_q,
    output sbr_state_e state_d,
    output logic       accept
);
    assign accept = (state_q == ST_IDLE) && req;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req) state_d = ST_STROBE;
            ST_STROBE:  if (timer_done) state_d = ST_RECOVER;
            ST_RECOVER: state_d = ST_ACK;
            ST_ACK:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    a_r8_no_start_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sbr_pin_ctrl.sv
// Module: sbr_pin_ctrl
// Registers every memory pin and the host acknowledge and read data from
// the sequencer's next state. It latches the request at acceptance.
// Assumes the request fields are valid in the accepting cycle.
module sbr_pin_ctrl
    import sram16_bridge_pkg::*;
#(
    parameter int WORD_AW = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  sbr_state_e            state_q,
    input  sbr_state_e            state_d,
    input  logic                  accept,
    input  sbr_req_t              req_in,
    input  logic [WORD_AW-1:0]    word_adr,
    input  logic [SBR_DATA_W-1:0] dq_in,
    output logic [WORD_AW-1:0]    mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [SBR_LANES-1:0]  mem_lane_n,
    output logic [SBR_DATA_W-1:0] mem_dq_out,
    output logic                  mem_dq_drive,
    output logic [SBR_DATA_W-1:0] rdat,
    output logic                  ack
);
    sbr_req_t req_q;
    sbr_req_t cur;
    logic     active_d;
    logic     strobe_d;
    logic     capture;

    assign cur      = accept ? req_in : req_q;
    assign active_d = (state_d == ST_STROBE) || (state_d == ST_RECOVER);
    assign strobe_d = (state_d == ST_STROBE);
    assign capture  = (state_q == ST_STROBE) && (state_d == ST_RECOVER) && !req_q.we;

    // hold the accepted request for the whole access
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= '{we: 1'b0, lane_n: '1, wdat: '0};
        else if (accept) req_q <= req_in;
    end

    // address and write data: load at acceptance, held until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= word_adr;
            mem_dq_out <= req_in.wdat;
        end
    end

    // strobes, lane enables and bus drive follow the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n     <= 1'b1;
            mem_we_n     <= 1'b1;
            mem_oe_n     <= 1'b1;
            mem_lane_n   <= '1;
            mem_dq_drive <= 1'b0;
        end else begin
            mem_ce_n     <= !active_d;
            mem_we_n     <= !(strobe_d && cur.we);
            mem_oe_n     <= !(strobe_d && !cur.we);
            mem_lane_n   <= active_d ? cur.lane_n : '1;
            mem_dq_drive <= strobe_d && cur.we;
        end
    end

    // read capture at the end of the last strobe cycle, acknowledge pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdat <= '0;
            ack  <= 1'b0;
        end else begin
            if (capture) rdat <= dq_in;
            ack <= (state_d == ST_ACK);
        end
    end

    a_r1_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
    a_r5_drive_only_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drive |-> (!mem_we_n && mem_oe_n));
    a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_drive && mem_we_n));
    a_r7_we_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $rose(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
    a_r2_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_lane_n == '1));
endmodule

// File: rtl/sram16_bridge.sv
// Module: sram16_bridge (top)
// Bridges a byte-addressed classic host to a 16-bit asynchronous SRAM.
// Assumes single transfers only; the data bus tri-state is in the pad ring.
module sram16_bridge
    import sram16_bridge_pkg::*;
#(
    parameter int HOST_AW     = 21,
    parameter int WAIT_CYCLES = 2,
    localparam int WORD_AW    = HOST_AW - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_cyc,
    input  logic                  host_stb,
    input  logic                  host_we,
    input  logic [HOST_AW-1:0]    host_adr,
    input  logic [SBR_LANES-1:0]  host_sel,
    input  logic [SBR_DATA_W-1:0] host_wdat,
    output logic [SBR_DATA_W-1:0] host_rdat,
    output logic                  host_ack,
    output logic [WORD_AW-1:0]    sram_addr,
    output logic                  sram_ce_n,
    output logic                  sram_we_n,
    output logic                  sram_oe_n,
    output logic                  sram_lb_n,
    output logic                  sram_ub_n,
    output logic [SBR_DATA_W-1:0] sram_dq_out,
    output logic                  sram_dq_drive,
    input  logic [SBR_DATA_W-1:0] sram_dq_in
);
    logic [WORD_AW-1:0]   word_adr;
    logic [SBR_LANES-1:0] lane_en_n;
    logic [SBR_LANES-1:0] mem_lane_n;
    logic                 req;
    logic                 accept;
    logic                 timer_done;
    sbr_state_e           state_q;
    sbr_state_e           state_d;
    sbr_req_t             req_in;

    assign req    = host_cyc && host_stb;
    assign req_in = '{we: host_we, lane_n: lane_en_n, wdat: host_wdat};

    sbr_addr_map #(.HOST_AW(HOST_AW), .LANES(SBR_LANES)) u_map (
        .byte_adr_hi (host_adr[HOST_AW-1:1]),
        .byte_sel    (host_sel),
        .word_adr    (word_adr),
        .lane_en_n   (lane_en_n)
    );

    sbr_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .done  (timer_done)
    );

    sbr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .timer_done (timer_done),
        .state_q    (state_q),
        .state_d    (state_d),
        .accept     (accept)
    );

    sbr_pin_ctrl #(.WORD_AW(WORD_AW)) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .state_d      (state_d),
        .accept       (accept),
        .req_in       (req_in),
        .word_adr     (word_adr),
        .dq_in        (sram_dq_in),
        .mem_addr     (sram_addr),
        .mem_ce_n     (sram_ce_n),
        .mem_we_n     (sram_we_n),
        .mem_oe_n     (sram_oe_n),
        .mem_lane_n   (mem_lane_n),
        .mem_dq_out   (sram_dq_out),
        .mem_dq_drive (sram_dq_drive),
        .rdat         (host_rdat),
        .ack          (host_ack)
    );

    assign sram_lb_n = mem_lane_n[0];
    assign sram_ub_n = mem_lane_n[1];

    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    a_r7_ce_high_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> sram_ce_n);
    a_r2_byte_lane_matches_adr: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ($countones(host_sel) == 1)) |-> (host_sel[1] == host_adr[0]));
endmodule

// File: tb/test_sram16_bridge.sv
// Bench: behavioural phase model of the bridge, a 16-bit lane-masked
// memory, and a host-side reference memory; compared on every clock.
module test_sram16_bridge;
    localparam int W  = 3;
    localparam int AW = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cyc = 1'b0, host_stb = 1'b0, host_we = 1'b0;
    logic [20:0] host_adr = '0;
    logic [1:0]  host_sel = '0;
    logic [15:0] host_wdat = '0;
    logic [15:0] host_rdat;
    logic        host_ack;
    logic [19:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_drive;
    logic [15:0] sram_dq_in;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sram16_bridge #(.HOST_AW(AW), .WAIT_CYCLES(W)) i_sram16_bridge (
        .clk(clk), .rst_n(rst_n), .host_cyc(host_cyc), .host_stb(host_stb),
        .host_we(host_we), .host_adr(host_adr), .host_sel(host_sel),
        .host_wdat(host_wdat), .host_rdat(host_rdat), .host_ack(host_ack),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .sram_dq_out(sram_dq_out), .sram_dq_drive(sram_dq_drive),
        .sram_dq_in(sram_dq_in)
    );

    // memory model: index keeps the word address top bit and six low bits
    logic [15:0] mem [128];
    logic [15:0] ref_mem [128];
    initial for (int i = 0; i < 128; i++) begin mem[i] = '0; ref_mem[i] = '0; end

    assign sram_dq_in = (!sram_ce_n && !sram_oe_n) ? mem[{sram_addr[19], sram_addr[5:0]}] : 16'h0;

    always @(posedge clk) begin
        if (rst_n && !sram_ce_n && !sram_we_n && sram_dq_drive) begin
            if (!sram_lb_n) mem[{sram_addr[19], sram_addr[5:0]}][7:0]  <= sram_dq_out[7:0];
            if (!sram_ub_n) mem[{sram_addr[19], sram_addr[5:0]}][15:8] <= sram_dq_out[15:8];
        end
    end

    // reference phase model: 0 idle, 1..W strobe, W+1 recovery, W+2 ack
    int          ph = 0;
    logic        m_we;
    logic [20:0] m_adr;
    logic [1:0]  m_sel;
    logic [15:0] m_wdat, m_exp;
    bit          seen_reset = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            seen_reset = 1;
        end else if (ph == 0) begin
            if (host_cyc && host_stb) begin
                ph = 1; m_we = host_we; m_adr = host_adr; m_sel = host_sel; m_wdat = host_wdat;
                if (host_we) begin
                    if (host_sel[0]) ref_mem[{host_adr[20], host_adr[6:1]}][7:0]  = host_wdat[7:0];
                    if (host_sel[1]) ref_mem[{host_adr[20], host_adr[6:1]}][15:8] = host_wdat[15:8];
                end else begin
                    m_exp = ref_mem[{host_adr[20], host_adr[6:1]}];
                end
            end
        end else begin
            ph = (ph == W + 2) ? 0 : ph + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (seen_reset) begin
            logic act, strb, e_we, e_oe, e_drv;
            act   = (ph >= 1) && (ph <= W + 1);
            strb  = (ph >= 1) && (ph <= W);
            e_we  = !(strb && m_we);
            e_oe  = !(strb && !m_we);
            e_drv = strb && m_we;
            if (ph == 0) begin
                chk(sram_ce_n && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n
                    && !sram_dq_drive && !host_ack, "R6 idle pins",
                    {25'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_drive, host_ack},
                    32'h7C);
            end else begin
                chk(sram_ce_n == !act, "R7 chip select", 32'(sram_ce_n), 32'(!act));
                chk(host_ack == (ph == W + 2), "R7 ack pulse", 32'(host_ack), 32'(ph == W + 2));
                chk(sram_we_n == e_we, "R5 write enable", 32'(sram_we_n), 32'(e_we));
                chk(sram_oe_n == e_oe, "R4 output enable", 32'(sram_oe_n), 32'(e_oe));
                chk(sram_dq_drive == e_drv, "R5 bus drive", 32'(sram_dq_drive), 32'(e_drv));
                if (act) begin
                    chk(sram_addr === m_adr[20:1], "R1 word address", 32'(sram_addr), 32'(m_adr[20:1]));
                    chk({sram_ub_n, sram_lb_n} == ~m_sel, "R2 lane enables",
                        32'({sram_ub_n, sram_lb_n}), 32'(~m_sel));
                end
                if (e_drv)
                    chk(sram_dq_out == m_wdat, "R5 write data", 32'(sram_dq_out), 32'(m_wdat));
                if (ph == W + 2 && !m_we) begin
                    if (m_sel[0]) chk(host_rdat[7:0] == m_exp[7:0], "R3 R4 read low lane",
                                      32'(host_rdat[7:0]), 32'(m_exp[7:0]));
                    if (m_sel[1]) chk(host_rdat[15:8] == m_exp[15:8], "R3 R4 read high lane",
                                      32'(host_rdat[15:8]), 32'(m_exp[15:8]));
                end
            end
        end
    end

    // one host transfer; keep leaves the strobe high across the ack (R8)
    task automatic xfer(input bit we, input logic [20:0] adr, input logic [1:0] sel,
                        input logic [15:0] wd, input bit keep);
        @(negedge clk);
        host_cyc = 1; host_stb = 1; host_we = we; host_adr = adr; host_sel = sel; host_wdat = wd;
        do @(negedge clk); while (!host_ack);
        if (!keep) begin host_cyc = 0; host_stb = 0; end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R9: strobe without cycle starts nothing
        host_stb = 1; host_cyc = 0;
        repeat (6) @(negedge clk);
        chk(sram_ce_n, "R9 stb without cyc", 32'(sram_ce_n), 32'd1);
        host_stb = 0;
        // R1: two words differing only in the top address bit
        xfer(1, 21'h100040, 2'b11, 16'h1234, 0);
        xfer(1, 21'h000040, 2'b11, 16'h5678, 0);
        // R3: single-lane writes, even address lower lane, odd upper lane
        xfer(1, 21'h100040, 2'b01, 16'hFF99, 0);
        xfer(1, 21'h000041, 2'b10, 16'hAAFF, 0);
        xfer(0, 21'h100040, 2'b11, 16'h0, 0);
        xfer(0, 21'h000040, 2'b11, 16'h0, 0);
        xfer(0, 21'h100041, 2'b10, 16'h0, 0);
        xfer(0, 21'h000040, 2'b01, 16'h0, 0);
        // R8: back-to-back with the strobe held
        xfer(1, 21'h00007E, 2'b11, 16'hC3A5, 1);
        xfer(0, 21'h00007E, 2'b11, 16'h0, 1);
        xfer(0, 21'h1FFFFE, 2'b11, 16'h0, 0);
        // mixed traffic
        for (int n = 0; n < 60; n++) begin
            logic [20:0] a;
            logic [1:0]  s;
            a = 21'($urandom) & 21'h10007F;
            case ($urandom % 3)
                0:       begin s = 2'b11; a[0] = 1'b0; end
                default: s = a[0] ? 2'b10 : 2'b01;
            endcase
            xfer($urandom % 2, a, s, 16'($urandom), ($urandom % 4) == 0);
        end
        @(negedge clk); host_cyc = 0; host_stb = 0;
        repeat (W + 4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule